// File: doc/BRIEF.md
# Receive Interrupt Coalescing Controller

This block sits on the device side of one receive channel. It counts frames as they arrive and decides when to interrupt the host. An interrupt is raised once the number of waiting frames reaches a programmed count, or once a programmed time window has run out while something is waiting. Each interrupt comes with a status word. The status word holds a 4-bit rolling tag, the number of frames the interrupt covers, and a flag for a transmit-chain event.

After an interrupt, the controller does not raise another until the host acknowledges it. The host does this by writing the tag it expects next, which is the last tag plus one, wrapping at 16. An acknowledge with any other value is ignored. Frames that arrive in the meantime are held over for the next interrupt.

A control register is written through separate set and clear ports. It holds three bits: an uncached-memory flag, a hold bit that keeps the receive path in reset, and the interrupt enable. A second register holds the count limit and the time limit. The time limit is counted in units of `TICKS_PER_UNIT` microsecond ticks, which is 100 by default.

Top module: `rxirq_coalescer`

## Requirements
- R1: After reset, `ctl_word` is 0x0002_0000 (only the hold bit set), `lim_word` is 0x0A10 (count limit 16, time limit 10), `status_word` is 0 and `irq` is low.
- R2: In `ctl_word`, bit 16 is the uncached flag, bit 17 is the hold bit and bit 18 is the interrupt enable. A set strobe ORs in the matching bits of `ctl_wdata`. A clear strobe removes them. When both strobes arrive in the same cycle, the clear wins. All other bits read as zero.
- R3: A write to `lim_wdata` loads the frame-count limit from bits 7:0 and the time limit from bits 15:8. `lim_word` reads back the same layout.
- R4: While the hold bit is set, frame strobes are discarded and nothing is pending. After the hold bit is cleared, counting starts from zero.
- R5: When the pending frame count reaches a nonzero value at or above the count limit, the interrupt is raised on the following clock edge.
- R6: While something is pending, the interrupt is raised once the number of ticks counted reaches the time limit times `TICKS_PER_UNIT`. The tick counter restarts at every interrupt and only runs while something is pending and no interrupt is outstanding.
- R7: Ticks with nothing pending never raise an interrupt.
- R8: An outstanding interrupt ends only when an acknowledge carries the status tag plus one, modulo 16. Any other acknowledge value leaves `irq` and `status_word` unchanged.
- R9: The tag in status bits 3:0 starts at 0, advances by one with each accepted acknowledge, and wraps from 15 to 0.
- R10: The frame count in status bits 10:4 saturates at 127.
- R11: `irq` is high exactly when the enable bit is set and an interrupt is outstanding. Clearing the enable masks `irq` without losing the interrupt.
- R12: A `link_evt` strobe sets status bit 16 in the next interrupt and is then cleared. A link event with no frames still counts as pending for the timeout.
- R13: Frames that arrive while an interrupt is outstanding are kept for the next interrupt and do not change the current status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_set_we | input | 1 | Set strobe for control bits |
| ctl_clr_we | input | 1 | Clear strobe for control bits |
| ctl_wdata | input | 32 | Bit mask for set/clear |
| lim_we | input | 1 | Limit register write strobe |
| lim_wdata | input | 16 | Time limit [15:8], count limit [7:0] |
| ack_we | input | 1 | Acknowledge write strobe |
| ack_wdata | input | 4 | Acknowledged next tag |
| frame_rx | input | 1 | One received frame per cycle high |
| link_evt | input | 1 | Transmit-chain event strobe |
| us_tick | input | 1 | Microsecond tick |
| ctl_word | output | 32 | Control register readback |
| lim_word | output | 16 | Limit register readback |
| status_word | output | 32 | Status of the latest interrupt |
| irq | output | 1 | Interrupt line |

## Verification
Each strobe (frame, tick, acknowledge or register write) takes effect on the clock edge that samples it. A limit crossing adds one more registered step: `irq` and `status_word` change on the edge after the frame or tick that reaches the limit. An acknowledge and a change to the enable bit show on `irq` right after their own edge. The bench drives each strobe on a falling edge and keeps it high for whole cycles. It checks immediately after an edge where a result is due on that edge. It waits exactly one more falling edge where a limit crossing is involved. It also checks the cycle before each due point to show that no result appears early.

// File: rtl/rxirq_pkg.sv
package rxirq_pkg;

    localparam int TAG_W       = 4;
    localparam int CNT_W       = 7;
    localparam int LIM_W       = 8;
    localparam int BIT_UNC     = 16;
    localparam int BIT_HOLD    = 17;
    localparam int BIT_IEN     = 18;
    localparam int ST_LINK_BIT = 16;

    typedef struct packed {
        logic ien;
        logic hold;
        logic unc;
    } ctl_t;

    typedef struct packed {
        logic [LIM_W-1:0] tmo;
        logic [LIM_W-1:0] cnt;
    } lim_t;

    function automatic logic [31:0] make_status(input logic [TAG_W-1:0] tag,
                                                input logic [CNT_W-1:0] cnt,
                                                input logic link);
        logic [31:0] w;
        w = '0;
        w[TAG_W-1:0]           = tag;
        w[TAG_W+CNT_W-1:TAG_W] = cnt;
        w[ST_LINK_BIT]         = link;
        return w;
    endfunction

endpackage

// File: rtl/rxirq_ctl_reg.sv
module rxirq_ctl_reg
    import rxirq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        set_we,
    input  logic        clr_we,
    input  logic [31:0] wdata,
    output ctl_t        ctl
);
    ctl_t ctl_d, ctl_q;
    ctl_t mask;
    logic unused_wbits;

    assign mask.unc  = wdata[BIT_UNC];
    assign mask.hold = wdata[BIT_HOLD];
    assign mask.ien  = wdata[BIT_IEN];
    assign unused_wbits = ^{wdata[31:BIT_IEN+1], wdata[BIT_UNC-1:0]};

    always_comb begin
        ctl_d = ctl_q;
        if (set_we) ctl_d = ctl_d | mask;
        // clear is applied last so it wins over a same-cycle set
        if (clr_we) ctl_d = ctl_d & ~mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{ien: 1'b0, hold: 1'b1, unc: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ctl = ctl_q;
endmodule

// File: rtl/rxirq_limit_reg.sv
module rxirq_limit_reg
    import rxirq_pkg::*;
#(
    parameter int DEF_CNT_LIM  = 16,
    parameter int DEF_TIME_LIM = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [15:0] wdata,
    output lim_t        lim
);
    lim_t lim_d, lim_q;

    always_comb begin
        lim_d = lim_q;
        if (we) begin
            lim_d.cnt = wdata[LIM_W-1:0];
            lim_d.tmo = wdata[2*LIM_W-1:LIM_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lim_q.cnt <= LIM_W'(DEF_CNT_LIM);
            lim_q.tmo <= LIM_W'(DEF_TIME_LIM);
        end else begin
            lim_q <= lim_d;
        end
    end

    assign lim = lim_q;
endmodule

// File: rtl/rxirq_timer.sv
module rxirq_timer
    import rxirq_pkg::*;
#(
    parameter int TICKS_PER_UNIT = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic             us_tick,
    input  logic [LIM_W-1:0] time_lim,
    output logic             expired
);
    localparam int MAX_TICKS = ((1 << LIM_W) - 1) * TICKS_PER_UNIT;
    localparam int TMO_W     = $clog2(MAX_TICKS + 1);

    typedef struct packed {
        logic [TMO_W-1:0] ticks;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic [TMO_W-1:0] thresh;

    assign thresh  = TMO_W'(time_lim) * TMO_W'(TICKS_PER_UNIT);
    assign expired = (tmr_q.ticks >= thresh);

    always_comb begin
        tmr_d = tmr_q;
        if (!run || restart) begin
            tmr_d.ticks = '0;
        end else if (us_tick && (tmr_q.ticks != {TMO_W{1'b1}})) begin
            tmr_d.ticks = tmr_q.ticks + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end
endmodule

// File: rtl/rxirq_core.sv
module rxirq_core
    import rxirq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic [LIM_W-1:0] cnt_lim,
    input  logic             frame_rx,
    input  logic             link_evt,
    input  logic             ack_we,
    input  logic [TAG_W-1:0] ack_tag,
    input  logic             tmo_expired,
    output logic             raised,
    output logic             pending,
    output logic             raise_now,
    output logic [CNT_W-1:0] pend_cnt,
    output logic [31:0]      status_word
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic             raised;
        logic [TAG_W-1:0] tag;
        logic [CNT_W-1:0] cnt;
        logic             link;
        logic [31:0]      status;
    } core_t;

    core_t s_d, s_q;
    logic  cnt_hit;
    logic  ack_ok;

    assign cnt_hit   = (s_q.cnt != '0) && ({1'b0, s_q.cnt} >= cnt_lim);
    assign pending   = (s_q.cnt != '0) || s_q.link;
    assign raise_now = !s_q.raised && !hold && pending && (cnt_hit || tmo_expired);
    assign ack_ok    = s_q.raised && ack_we && (ack_tag == s_q.tag + 1'b1);

    always_comb begin
        s_d = s_q;
        if (ack_ok) begin
            s_d.raised = 1'b0;
            s_d.tag    = s_q.tag + 1'b1;
        end
        if (hold) begin
            s_d.cnt  = '0;
            s_d.link = 1'b0;
        end else if (raise_now) begin
            s_d.status = make_status(s_q.tag, s_q.cnt, s_q.link);
            s_d.raised = 1'b1;
            s_d.cnt    = frame_rx ? CNT_W'(1) : '0;
            s_d.link   = link_evt;
        end else begin
            if (frame_rx && (s_q.cnt != CNT_MAX)) s_d.cnt = s_q.cnt + 1'b1;
            if (link_evt) s_d.link = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign raised      = s_q.raised;
    assign pend_cnt    = s_q.cnt;
    assign status_word = s_q.status;
endmodule

// File: rtl/rxirq_coalescer.sv
module rxirq_coalescer
    import rxirq_pkg::*;
#(
    parameter int TICKS_PER_UNIT = 100,
    parameter int DEF_CNT_LIM    = 16,
    parameter int DEF_TIME_LIM   = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctl_set_we,
    input  logic        ctl_clr_we,
    input  logic [31:0] ctl_wdata,
    input  logic        lim_we,
    input  logic [15:0] lim_wdata,
    input  logic        ack_we,
    input  logic [3:0]  ack_wdata,
    input  logic        frame_rx,
    input  logic        link_evt,
    input  logic        us_tick,
    output logic [31:0] ctl_word,
    output logic [15:0] lim_word,
    output logic [31:0] status_word,
    output logic        irq
);
    ctl_t             ctl;
    lim_t             lim;
    logic             raised;
    logic             pending;
    logic             raise_now;
    logic             tmo_expired;
    logic [CNT_W-1:0] pend_cnt;

    rxirq_ctl_reg u_ctl (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_we (ctl_set_we),
        .clr_we (ctl_clr_we),
        .wdata  (ctl_wdata),
        .ctl    (ctl)
    );

    rxirq_limit_reg #(
        .DEF_CNT_LIM  (DEF_CNT_LIM),
        .DEF_TIME_LIM (DEF_TIME_LIM)
    ) u_lim (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (lim_we),
        .wdata (lim_wdata),
        .lim   (lim)
    );

    rxirq_timer #(
        .TICKS_PER_UNIT (TICKS_PER_UNIT)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (pending && !raised && !ctl.hold),
        .restart  (raise_now),
        .us_tick  (us_tick),
        .time_lim (lim.tmo),
        .expired  (tmo_expired)
    );

    rxirq_core u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .hold        (ctl.hold),
        .cnt_lim     (lim.cnt),
        .frame_rx    (frame_rx),
        .link_evt    (link_evt),
        .ack_we      (ack_we),
        .ack_tag     (ack_wdata),
        .tmo_expired (tmo_expired),
        .raised      (raised),
        .pending     (pending),
        .raise_now   (raise_now),
        .pend_cnt    (pend_cnt),
        .status_word (status_word)
    );

    always_comb begin
        ctl_word           = '0;
        ctl_word[BIT_UNC]  = ctl.unc;
        ctl_word[BIT_HOLD] = ctl.hold;
        ctl_word[BIT_IEN]  = ctl.ien;
    end

    assign lim_word = {lim.tmo, lim.cnt};
    assign irq      = ctl.ien & raised;
endmodule

// File: rtl/rxirq_coalescer_chk.sv
module rxirq_coalescer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] ctl_word,
    input logic [31:0] status_word,
    input logic        ack_we,
    input logic [3:0]  ack_wdata,
    input logic        irq,
    input logic        raised,
    input logic [6:0]  pend_cnt
);
    // R11: the line is never high without the enable and an open interrupt
    a_r11_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ctl_word[18] && raised));

    // R8: an open interrupt survives any cycle without the matching acknowledge
    a_r8_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (raised && !(ack_we && (ack_wdata == status_word[3:0] + 4'd1))) |=> raised);

    // R8: an interrupt only closes after an acknowledge strobe
    a_r8_close_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(raised) |-> $past(ack_we));

    // R13: the reported status stays fixed while the interrupt stays open
    a_r13_status_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (raised && $past(raised)) |-> $stable(status_word));

    // R4: the hold bit empties the pending count
    a_r4_hold_drops: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_word[17] |=> (pend_cnt == 7'd0));
endmodule

bind rxirq_coalescer rxirq_coalescer_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_word    (ctl_word),
    .status_word (status_word),
    .ack_we      (ack_we),
    .ack_wdata   (ack_wdata),
    .irq         (irq),
    .raised      (raised),
    .pend_cnt    (pend_cnt)
);

// File: tb/rxirq_coalescer_test.sv
module rxirq_coalescer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_set_we = 1'b0;
    logic        ctl_clr_we = 1'b0;
    logic [31:0] ctl_wdata = '0;
    logic        lim_we = 1'b0;
    logic [15:0] lim_wdata = '0;
    logic        ack_we = 1'b0;
    logic [3:0]  ack_wdata = '0;
    logic        frame_rx = 1'b0;
    logic        link_evt = 1'b0;
    logic        us_tick = 1'b0;
    logic [31:0] ctl_word;
    logic [15:0] lim_word;
    logic [31:0] status_word;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;
    logic [3:0] exp_tag = 4'd0;

    always #5ns clk = ~clk;

    rxirq_coalescer uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl_set_we  (ctl_set_we),
        .ctl_clr_we  (ctl_clr_we),
        .ctl_wdata   (ctl_wdata),
        .lim_we      (lim_we),
        .lim_wdata   (lim_wdata),
        .ack_we      (ack_we),
        .ack_wdata   (ack_wdata),
        .frame_rx    (frame_rx),
        .link_evt    (link_evt),
        .us_tick     (us_tick),
        .ctl_word    (ctl_word),
        .lim_word    (lim_word),
        .status_word (status_word),
        .irq         (irq)
    );

    function automatic logic [31:0] st(input logic [3:0] tag, input int cnt, input logic link);
        logic [31:0] w;
        w = '0;
        w[3:0]  = tag;
        w[10:4] = 7'(cnt);
        w[16]   = link;
        return w;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic frames(input int n);
        frame_rx = 1'b1;
        repeat (n) @(negedge clk);
        frame_rx = 1'b0;
    endtask

    task automatic ticks(input int n);
        us_tick = 1'b1;
        repeat (n) @(negedge clk);
        us_tick = 1'b0;
    endtask

    task automatic ctl_set(input logic [31:0] m);
        ctl_wdata = m; ctl_set_we = 1'b1;
        @(negedge clk);
        ctl_set_we = 1'b0;
    endtask

    task automatic ctl_clr(input logic [31:0] m);
        ctl_wdata = m; ctl_clr_we = 1'b1;
        @(negedge clk);
        ctl_clr_we = 1'b0;
    endtask

    task automatic lim_wr(input logic [15:0] v);
        lim_wdata = v; lim_we = 1'b1;
        @(negedge clk);
        lim_we = 1'b0;
    endtask

    task automatic ack(input logic [3:0] t);
        ack_wdata = t; ack_we = 1'b1;
        @(negedge clk);
        ack_we = 1'b0;
    endtask

    task automatic ack_ok;
        ack(exp_tag + 4'd1);
        exp_tag = exp_tag + 4'd1;
        chk("R8 irq low after matching ack", {31'b0, irq}, 32'd0);
    endtask

    task automatic t_reset;
        chk("R1 ctl_word reset", ctl_word, 32'h0002_0000);
        chk("R1 lim_word reset", {16'b0, lim_word}, 32'h0000_0A10);
        chk("R1 status reset", status_word, 32'h0);
        chk("R1 irq reset", {31'b0, irq}, 32'd0);
    endtask

    task automatic t_ctl;
        ctl_set(32'hFFFF_FFFF);
        chk("R2 set all", ctl_word, 32'h0007_0000);
        ctl_clr(32'h0001_0000);
        chk("R2 clear uncached", ctl_word, 32'h0006_0000);
        ctl_wdata = 32'h0001_0000; ctl_set_we = 1'b1; ctl_clr_we = 1'b1;
        @(negedge clk);
        ctl_set_we = 1'b0; ctl_clr_we = 1'b0;
        chk("R2 clear wins", ctl_word, 32'h0006_0000);
    endtask

    task automatic t_lim;
        lim_wr(16'h0503);
        chk("R3 limit layout", {16'b0, lim_word}, 32'h0000_0503);
    endtask

    task automatic t_hold;
        frames(40);
        cyc(2);
        ctl_clr(32'h0002_0000);
        cyc(3);
        chk("R4 held frames discarded", {31'b0, irq}, 32'd0);
        frames(3);
        cyc(1);
        chk("R4 counting from zero", status_word, st(exp_tag, 3, 1'b0));
        chk("R4 irq after release", {31'b0, irq}, 32'd1);
        ack_ok();
    endtask

    task automatic t_count;
        lim_wr(16'h0A04);
        frames(4);
        chk("R5 not early", {31'b0, irq}, 32'd0);
        cyc(1);
        chk("R5 irq on count", {31'b0, irq}, 32'd1);
        chk("R5 status", status_word, st(exp_tag, 4, 1'b0));
        ack_ok();
    endtask

    task automatic t_wrong_ack;
        frames(4);
        cyc(1);
        chk("R8 raised", {31'b0, irq}, 32'd1);
        ack(exp_tag + 4'd3);
        chk("R8 wrong ack irq", {31'b0, irq}, 32'd1);
        chk("R8 wrong ack status", status_word, st(exp_tag, 4, 1'b0));
        ack(exp_tag);
        chk("R8 stale ack irq", {31'b0, irq}, 32'd1);
        ack_ok();
    endtask

    task automatic t_accum;
        frames(4);
        cyc(1);
        frames(2);
        cyc(3);
        chk("R13 still raised", {31'b0, irq}, 32'd1);
        chk("R13 status unchanged", status_word, st(exp_tag, 4, 1'b0));
        ack_ok();
        cyc(2);
        chk("R13 below limit no irq", {31'b0, irq}, 32'd0);
        frames(2);
        cyc(1);
        chk("R13 carried frames", status_word, st(exp_tag, 4, 1'b0));
        ack_ok();
    endtask

    task automatic t_timeout;
        lim_wr(16'h017F);
        frames(2);
        ticks(99);
        cyc(2);
        chk("R6 not before limit", {31'b0, irq}, 32'd0);
        ticks(1);
        chk("R6 not on expiry edge", {31'b0, irq}, 32'd0);
        cyc(1);
        chk("R6 irq on timeout", {31'b0, irq}, 32'd1);
        chk("R6 status", status_word, st(exp_tag, 2, 1'b0));
        ack_ok();
    endtask

    task automatic t_idle;
        ticks(300);
        cyc(2);
        chk("R7 idle ticks", {31'b0, irq}, 32'd0);
    endtask

    task automatic t_sat;
        lim_wr(16'h01FF);
        frames(130);
        ticks(100);
        cyc(1);
        chk("R10 irq", {31'b0, irq}, 32'd1);
        chk("R10 saturated count", status_word, st(exp_tag, 127, 1'b0));
        ack_ok();
    endtask

    task automatic t_link;
        link_evt = 1'b1;
        @(negedge clk);
        link_evt = 1'b0;
        ticks(100);
        cyc(1);
        chk("R12 link-only irq", {31'b0, irq}, 32'd1);
        chk("R12 link flag", status_word, st(exp_tag, 0, 1'b1));
        ack_ok();
        frames(1);
        ticks(100);
        cyc(1);
        chk("R12 flag cleared", status_word, st(exp_tag, 1, 1'b0));
        ack_ok();
    endtask

    task automatic t_ien;
        lim_wr(16'h0A01);
        frames(1);
        cyc(1);
        chk("R11 irq up", {31'b0, irq}, 32'd1);
        ctl_clr(32'h0004_0000);
        chk("R11 masked", {31'b0, irq}, 32'd0);
        ctl_set(32'h0004_0000);
        chk("R11 unmasked", {31'b0, irq}, 32'd1);
        ack_ok();
    endtask

    task automatic t_roll;
        for (int i = 0; i < 8; i++) begin
            frames(1);
            cyc(1);
            chk("R9 tag sequence", {28'b0, status_word[3:0]}, {28'b0, exp_tag});
            ack_ok();
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        t_ctl();
        t_lim();
        ctl_set(32'h0002_0000);
        t_hold();
        t_count();
        t_wrong_ack();
        t_accum();
        t_timeout();
        t_idle();
        t_sat();
        t_link();
        t_ien();
        t_roll();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule